// File: doc/BRIEF.md
# Single-Bit Alias Bridge

This block sits between a memory-mapped bus master and a word-wide memory or register space. Two address windows act as bit aliases. Each bit of a target region owns its own word-aligned alias address. A read from an alias address returns that one bit. A write to an alias address sets or clears that one bit through a read-modify-write sequence that the bridge runs on its own. No other access reaches the memory port while that sequence is in progress.

Any access outside the two alias windows passes straight to the memory port in the same cycle, unchanged. This includes direct accesses to the target regions. Both sides use a valid/ready request channel. Read data comes back on a separate response strobe.

The bridge keeps at most one read or read-modify-write outstanding. While one is in progress, it holds the master's ready low.

Top module: `bb_bridge`

## Requirements
- R1: While reset is asserted and until the first accepted request, the bridge drives no memory request (`s_valid` low) and no read response (`m_rvalid` low).
- R2: When the bridge is idle and a request falls outside both alias windows, it appears on the memory port in the same cycle. Address, direction and write data are unchanged, `m_ready` equals `s_ready`, and plain read data is returned unchanged.
- R3: Alias window 0 covers 0x2200_0000–0x23FF_FFFF and maps onto the target region at 0x2000_0000. Alias window 1 covers 0x4200_0000–0x43FF_FFFF and maps onto the target region at 0x4000_0000. Every other address is treated as a plain access, including 0x21FF_FFFC, 0x2400_0000 and the target regions themselves.
- R4: For an alias address A in a window with alias base AB and target base TB, let k = (A - AB) >> 5. The target word is TB + (k with its two low bits cleared). The bit index is 8 × (k mod 4) + A[4:2]. Bits A[1:0] are ignored.
- R5: An alias read issues one memory read of the target word. In the cycle the memory returns data, the master receives the selected bit in data bit 0, with all other data bits zero.
- R6: An alias write changes only the selected bit of the target word, setting it to bit 0 of the write data. Write data bits 31:1 are ignored, and all other bits of the word keep their value.
- R7: From the cycle after a read or alias write is accepted, `m_ready` stays low. It stays low until the read response has been returned, or until the write-back has been accepted by the memory.
- R8: An alias write produces exactly two memory requests, in this order: a read of the target word, then a write of the same word. No other memory request occurs between them.
- R9: The write-back request of an alias write is driven in the cycle right after the memory's read response.
- R10: `m_rvalid` is asserted only while an accepted read is awaiting its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_valid | input | 1 | Master request valid |
| m_ready | output | 1 | Bridge accepts master request |
| m_write | input | 1 | Master request is a write |
| m_addr | input | 32 | Master byte address |
| m_wdata | input | 32 | Master write data |
| m_rvalid | output | 1 | Read response valid to master |
| m_rdata | output | 32 | Read response data to master |
| s_valid | output | 1 | Memory request valid |
| s_ready | input | 1 | Memory accepts request |
| s_write | output | 1 | Memory request is a write |
| s_addr | output | 32 | Memory word address |
| s_wdata | output | 32 | Memory write data |
| s_rvalid | input | 1 | Memory read response valid |
| s_rdata | input | 32 | Memory read response data |

## Verification
Results arrive on a fixed schedule:
- A pass-through request is due on the memory port in the same cycle it is presented.
- A read result reaches the master in the same cycle the memory returns it.
- An alias write-back request is due exactly one cycle after the memory's read response.
- The master may not be ready again until the cycle after the write-back is accepted.

The bench's memory model uses varying ready stalls and one- or two-cycle read latency. A behavioural model tracks the busy, read-pending and write-back-due conditions from the port handshakes at each rising edge. At every falling edge the bench compares the ports against that model, so each result is checked in the exact cycle it is due. After every alias write, the bench also checks the memory request log and the word held in memory.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int ADDR_W   = 32;
  localparam int DATA_W   = 32;
  localparam int BIDX_W   = $clog2(DATA_W);
  localparam int LANE_W   = $clog2(DATA_W / 8);
  localparam int SUBBIT_W = 3;
  localparam int REGION_W = 20;
  localparam int ALIAS_W  = REGION_W + SUBBIT_W + 2;
  localparam int NUM_WIN  = 2;

  localparam logic [NUM_WIN-1:0][ADDR_W-1:0] DEF_ALIAS_BASE = {32'h4200_0000, 32'h2200_0000};
  localparam logic [NUM_WIN-1:0][ADDR_W-1:0] DEF_TGT_BASE   = {32'h4000_0000, 32'h2000_0000};

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RD_WAIT = 2'd1,
    ST_RMW_RD  = 2'd2,
    ST_RMW_WR  = 2'd3
  } bb_state_e;

  typedef struct packed {
    logic              hit;
    logic [ADDR_W-1:0] word_addr;
    logic [BIDX_W-1:0] bit_idx;
  } bb_xlate_t;
endpackage

// File: rtl/bb_rst_sync.sv
module bb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/bb_win_decode.sv
module bb_win_decode
  import bb_pkg::*;
#(
  parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'h2200_0000,
  parameter logic [ADDR_W-1:0] TGT_BASE   = 32'h2000_0000
) (
  input  logic [ADDR_W-1:2] word_i,
  output bb_xlate_t         xl_o
);
  logic [ALIAS_W-1:2]  off;
  logic [REGION_W-1:0] byte_off;

  assign off      = word_i[ALIAS_W-1:2];
  assign byte_off = off[ALIAS_W-1:SUBBIT_W+2];

  always_comb begin
    xl_o.hit       = (word_i[ADDR_W-1:ALIAS_W] == ALIAS_BASE[ADDR_W-1:ALIAS_W]);
    xl_o.word_addr = TGT_BASE |
                     {{(ADDR_W-REGION_W){1'b0}}, byte_off[REGION_W-1:LANE_W], {LANE_W{1'b0}}};
    xl_o.bit_idx   = {byte_off[LANE_W-1:0], off[SUBBIT_W+1:2]};
  end
endmodule

// File: rtl/bb_alias_xlate.sv
module bb_alias_xlate
  import bb_pkg::*;
#(
  parameter int                                 N_WIN       = NUM_WIN,
  parameter logic [N_WIN-1:0][ADDR_W-1:0]       ALIAS_BASES = DEF_ALIAS_BASE,
  parameter logic [N_WIN-1:0][ADDR_W-1:0]       TGT_BASES   = DEF_TGT_BASE
) (
  input  logic [ADDR_W-1:2] word_i,
  output bb_xlate_t         xl_o
);
  bb_xlate_t win_xl [N_WIN];

  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    bb_win_decode #(
      .ALIAS_BASE(ALIAS_BASES[g]),
      .TGT_BASE  (TGT_BASES[g])
    ) i_win (
      .word_i(word_i),
      .xl_o  (win_xl[g])
    );
  end

  // Lowest-numbered matching window wins.
  always_comb begin
    xl_o = '0;
    for (int i = N_WIN - 1; i >= 0; i--) begin
      if (win_xl[i].hit) xl_o = win_xl[i];
    end
  end
endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge
  import bb_pkg::*;
(
  input  logic [DATA_W-1:0] word_i,
  input  logic [BIDX_W-1:0] idx_i,
  input  logic              set_i,
  output logic              bit_o,
  output logic [DATA_W-1:0] word_o
);
  assign bit_o = word_i[idx_i];

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign word_o[b] = (idx_i == BIDX_W'(b)) ? set_i : word_i[b];
  end
endmodule

// File: rtl/bb_ctrl.sv
module bb_ctrl
  import bb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m_valid,
  input  logic              m_write,
  input  logic [ADDR_W-1:0] m_addr,
  input  logic [DATA_W-1:0] m_wdata,
  output logic              m_ready,
  output logic              m_rvalid,
  output logic [DATA_W-1:0] m_rdata,
  input  bb_xlate_t         xl_i,
  output logic              s_valid,
  output logic              s_write,
  output logic [ADDR_W-1:0] s_addr,
  output logic [DATA_W-1:0] s_wdata,
  input  logic              s_ready,
  input  logic              s_rvalid,
  input  logic [DATA_W-1:0] s_rdata,
  output logic [BIDX_W-1:0] idx_o,
  output logic              set_o,
  input  logic              bit_i,
  input  logic [DATA_W-1:0] merged_i
);
  bb_state_e         state_q, state_d;
  logic [BIDX_W-1:0] idx_q;
  logic              set_q;
  logic [ADDR_W-1:0] waddr_q;
  logic              alias_rd_q;
  logic [DATA_W-1:0] word_q;
  logic              cap_en;
  logic              word_en;

  always_comb begin
    state_d  = state_q;
    m_ready  = 1'b0;
    m_rvalid = 1'b0;
    m_rdata  = s_rdata;
    s_valid  = 1'b0;
    s_write  = 1'b0;
    s_addr   = m_addr;
    s_wdata  = m_wdata;
    cap_en   = 1'b0;
    word_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        s_valid = m_valid;
        s_write = m_write && !xl_i.hit;
        s_addr  = xl_i.hit ? xl_i.word_addr : m_addr;
        m_ready = s_ready;
        if (m_valid && s_ready) begin
          cap_en = 1'b1;
          if (!m_write)       state_d = ST_RD_WAIT;
          else if (xl_i.hit)  state_d = ST_RMW_RD;
        end
      end
      ST_RD_WAIT: begin
        m_rvalid = s_rvalid;
        if (alias_rd_q) m_rdata = {{(DATA_W-1){1'b0}}, bit_i};
        if (s_rvalid) state_d = ST_IDLE;
      end
      ST_RMW_RD: begin
        if (s_rvalid) begin
          word_en = 1'b1;
          state_d = ST_RMW_WR;
        end
      end
      ST_RMW_WR: begin
        s_valid = 1'b1;
        s_write = 1'b1;
        s_addr  = waddr_q;
        s_wdata = word_q;
        if (s_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign idx_o = idx_q;
  assign set_o = set_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q      <= '0;
      set_q      <= 1'b0;
      waddr_q    <= '0;
      alias_rd_q <= 1'b0;
    end else if (cap_en) begin
      idx_q      <= xl_i.bit_idx;
      set_q      <= m_wdata[0];
      waddr_q    <= xl_i.word_addr;
      alias_rd_q <= xl_i.hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= merged_i;
  end
endmodule

// File: rtl/bb_bridge.sv
module bb_bridge
  import bb_pkg::*;
#(
  parameter int                           N_WIN       = NUM_WIN,
  parameter logic [N_WIN-1:0][ADDR_W-1:0] ALIAS_BASES = DEF_ALIAS_BASE,
  parameter logic [N_WIN-1:0][ADDR_W-1:0] TGT_BASES   = DEF_TGT_BASE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m_valid,
  output logic              m_ready,
  input  logic              m_write,
  input  logic [ADDR_W-1:0] m_addr,
  input  logic [DATA_W-1:0] m_wdata,
  output logic              m_rvalid,
  output logic [DATA_W-1:0] m_rdata,
  output logic              s_valid,
  input  logic              s_ready,
  output logic              s_write,
  output logic [ADDR_W-1:0] s_addr,
  output logic [DATA_W-1:0] s_wdata,
  input  logic              s_rvalid,
  input  logic [DATA_W-1:0] s_rdata
);
  logic              rst_sync_n;
  bb_xlate_t         xl;
  logic [BIDX_W-1:0] idx;
  logic              set_val;
  logic              sel_bit;
  logic [DATA_W-1:0] merged;

  bb_rst_sync i_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  bb_alias_xlate #(
    .N_WIN      (N_WIN),
    .ALIAS_BASES(ALIAS_BASES),
    .TGT_BASES  (TGT_BASES)
  ) i_xlate (
    .word_i(m_addr[ADDR_W-1:2]),
    .xl_o  (xl)
  );

  bb_bit_merge i_merge (
    .word_i(s_rdata),
    .idx_i (idx),
    .set_i (set_val),
    .bit_o (sel_bit),
    .word_o(merged)
  );

  bb_ctrl i_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .m_valid (m_valid),
    .m_write (m_write),
    .m_addr  (m_addr),
    .m_wdata (m_wdata),
    .m_ready (m_ready),
    .m_rvalid(m_rvalid),
    .m_rdata (m_rdata),
    .xl_i    (xl),
    .s_valid (s_valid),
    .s_write (s_write),
    .s_addr  (s_addr),
    .s_wdata (s_wdata),
    .s_ready (s_ready),
    .s_rvalid(s_rvalid),
    .s_rdata (s_rdata),
    .idx_o   (idx),
    .set_o   (set_val),
    .bit_i   (sel_bit),
    .merged_i(merged)
  );
endmodule

// File: rtl/bb_bridge_chk.sv
module bb_bridge_chk
  import bb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              m_valid,
  input logic              m_ready,
  input logic              m_write,
  input logic [ADDR_W-1:0] m_addr,
  input logic [DATA_W-1:0] m_wdata,
  input logic              m_rvalid,
  input logic [DATA_W-1:0] m_rdata,
  input logic              s_valid,
  input logic              s_ready,
  input logic              s_write,
  input logic [ADDR_W-1:0] s_addr,
  input logic [DATA_W-1:0] s_wdata,
  input logic              s_rvalid,
  input logic [DATA_W-1:0] s_rdata
);
  function automatic logic in_alias(input logic [ADDR_W-1:0] a);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (a[ADDR_W-1:ALIAS_W] == DEF_ALIAS_BASE[i][ADDR_W-1:ALIAS_W]) r = 1'b1;
    end
    return r;
  endfunction

  logic              acc;
  logic              pend_rmw, have_old, rd_out, rd_alias;
  logic [ADDR_W-1:0] rmw_addr;
  logic [DATA_W-1:0] rmw_old;

  assign acc = m_valid && m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_rmw <= 1'b0;
      have_old <= 1'b0;
      rd_out   <= 1'b0;
      rd_alias <= 1'b0;
      rmw_addr <= '0;
      rmw_old  <= '0;
    end else begin
      if (acc && m_write && in_alias(m_addr)) begin
        pend_rmw <= 1'b1;
        have_old <= 1'b0;
        rmw_addr <= s_addr;
      end else if (pend_rmw && s_valid && s_ready && s_write) begin
        pend_rmw <= 1'b0;
      end
      if (pend_rmw && s_rvalid) begin
        rmw_old  <= s_rdata;
        have_old <= 1'b1;
      end
      if (acc && !m_write) begin
        rd_out   <= 1'b1;
        rd_alias <= in_alias(m_addr);
      end else if (m_rvalid) begin
        rd_out <= 1'b0;
      end
    end
  end

  a_r2_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_alias(m_addr) |-> s_valid && s_addr == m_addr && s_write == m_write &&
                                  (!m_write || s_wdata == m_wdata));

  a_r7_hold_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_rmw || rd_out) |-> !m_ready);

  a_r8_same_word: assert property (@(posedge clk) disable iff (!rst_n)
    pend_rmw && s_valid |-> s_write && s_addr == rmw_addr);

  a_r6_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    pend_rmw && have_old && s_valid && s_write |-> $countones(s_wdata ^ rmw_old) <= 1);

  a_r5_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_out && rd_alias && m_rvalid |-> m_rdata[DATA_W-1:1] == '0);

  a_r10_no_stray_resp: assert property (@(posedge clk) disable iff (!rst_n)
    m_rvalid |-> rd_out);

  a_r9_wb_next: assert property (@(posedge clk) disable iff (!rst_n)
    pend_rmw && s_rvalid |=> s_valid && s_write);
endmodule

bind bb_bridge bb_bridge_chk i_chk (.*);

// File: tb/test_bb_bridge.sv
module test_bb_bridge;
  logic        clk, rst_n;
  logic        m_valid, m_ready, m_write, m_rvalid;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic        s_valid, s_ready, s_write, s_rvalid;
  logic [31:0] s_addr, s_wdata, s_rdata;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;

  bb_bridge i_bb_bridge (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // ---------------- requirement-level reference helpers ----------------
  function automatic bit is_al(input logic [31:0] a);
    return (a >= 32'h2200_0000 && a < 32'h2400_0000) ||
           (a >= 32'h4200_0000 && a < 32'h4400_0000);
  endfunction

  function automatic logic [31:0] al_word(input logic [31:0] a);
    logic [31:0] ab, tb, k;
    ab = (a >= 32'h4200_0000) ? 32'h4200_0000 : 32'h2200_0000;
    tb = (a >= 32'h4200_0000) ? 32'h4000_0000 : 32'h2000_0000;
    k  = (a - ab) >> 5;
    return tb + (k & ~32'd3);
  endfunction

  function automatic int al_bit(input logic [31:0] a);
    logic [31:0] ab, k;
    ab = (a >= 32'h4200_0000) ? 32'h4200_0000 : 32'h2200_0000;
    k  = (a - ab) >> 5;
    return int'(k % 4) * 8 + int'((a >> 2) & 32'd7);
  endfunction

  logic [31:0] mem  [bit [31:0]];
  logic [31:0] gold [bit [31:0]];

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction
  function automatic logic [31:0] gold_rd(input logic [31:0] a);
    return gold.exists(a) ? gold[a] : 32'h0;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // ---------------- memory model ----------------
  logic [15:0] lfsr;
  logic        resp_pend;
  logic [1:0]  resp_cnt;
  logic [31:0] resp_addr;
  bit          log_wr [$];
  logic [31:0] log_addr [$];

  // bench view of bridge state, derived from port handshakes
  logic        rmw_busy, rd_pend, wb_due;
  logic [31:0] rmw_word;
  bit          started;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr      <= 16'hACE1;
      s_ready   <= 1'b0;
      s_rvalid  <= 1'b0;
      s_rdata   <= 32'h0;
      resp_pend <= 1'b0;
      resp_cnt  <= 2'd0;
      resp_addr <= 32'h0;
      rmw_busy  <= 1'b0;
      rd_pend   <= 1'b0;
      wb_due    <= 1'b0;
      rmw_word  <= 32'h0;
    end else begin
      cyc      <= cyc + 1;
      lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      s_ready  <= lfsr[2] | lfsr[5];
      s_rvalid <= 1'b0;
      if (resp_pend) begin
        if (resp_cnt == 2'd0) begin
          s_rvalid  <= 1'b1;
          s_rdata   <= mem_rd(resp_addr);
          resp_pend <= 1'b0;
        end else begin
          resp_cnt <= resp_cnt - 2'd1;
        end
      end
      if (s_valid && s_ready) begin
        log_wr.push_back(s_write);
        log_addr.push_back(s_addr);
        if (s_write) mem[s_addr] = s_wdata;
        else begin
          resp_pend <= 1'b1;
          resp_addr <= s_addr;
          resp_cnt  <= {1'b0, lfsr[7]};
        end
      end
      wb_due <= s_rvalid && rmw_busy;
      if (m_valid && m_ready) begin
        if (m_write && is_al(m_addr)) begin
          rmw_busy <= 1'b1;
          rmw_word <= al_word(m_addr);
        end else if (!m_write) rd_pend <= 1'b1;
      end
      if (s_valid && s_ready && s_write && rmw_busy) rmw_busy <= 1'b0;
      if (m_rvalid) rd_pend <= 1'b0;
    end
  end

  // every-clock comparison against the bench model
  always @(negedge clk) begin
    if (rst_n && started) begin
      if (rmw_busy || rd_pend)
        check(!m_ready, "R7 ready held low", {31'b0, m_ready}, 32'h0);
      if (m_rvalid)
        check(rd_pend, "R10 response only when read pending", {31'b0, rd_pend}, 32'h1);
      if (wb_due)
        check(s_valid && s_write && s_addr == rmw_word, "R9 write-back one cycle after response",
              s_addr, rmw_word);
      if (m_valid && m_ready && !is_al(m_addr) && !rmw_busy && !rd_pend)
        check(s_valid && s_addr == m_addr && s_write == m_write &&
              (!m_write || s_wdata == m_wdata), "R2 same-cycle pass-through", s_addr, m_addr);
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  // ---------------- driver ----------------
  task automatic xfer(input bit wr, input logic [31:0] a, input logic [31:0] d, output logic [31:0] r);
    log_wr.delete();
    log_addr.delete();
    @(negedge clk);
    m_valid = 1'b1; m_write = wr; m_addr = a; m_wdata = d;
    while (!m_ready) @(negedge clk);
    @(negedge clk);
    m_valid = 1'b0;
    r = 32'h0;
    if (!wr) begin
      while (!m_rvalid) @(negedge clk);
      r = m_rdata;
    end
    while (rmw_busy || rd_pend) @(negedge clk);
  endtask

  task automatic plain_wr(input logic [31:0] a, input logic [31:0] d);
    logic [31:0] r;
    xfer(1'b1, a, d, r);
    gold[a] = d;
    check(mem_rd(a) == d, "R2/R3 plain write reaches memory unchanged", mem_rd(a), d);
  endtask

  task automatic plain_rd(input logic [31:0] a);
    logic [31:0] r;
    xfer(1'b0, a, 32'h0, r);
    check(r == gold_rd(a), "R2/R3 plain read data", r, gold_rd(a));
  endtask

  task automatic alias_wr(input logic [31:0] a, input logic [31:0] d);
    logic [31:0] r, w, e;
    w = al_word(a);
    xfer(1'b1, a, d, r);
    e = gold_rd(w);
    e[al_bit(a)] = d[0];
    gold[w] = e;
    check(mem_rd(w) == e, "R4/R6 alias write updates one bit", mem_rd(w), e);
    check(log_wr.size() == 2 && log_wr[0] == 1'b0 && log_wr[1] == 1'b1 &&
          log_addr[0] == w && log_addr[1] == w, "R8 read then write of same word",
          32'(log_wr.size()), 32'd2);
  endtask

  task automatic alias_rd(input logic [31:0] a);
    logic [31:0] r, e;
    xfer(1'b0, a, 32'h0, r);
    e = {31'b0, gold_rd(al_word(a))[al_bit(a)]};
    check(r == e, "R5 alias read returns bit in data bit 0", r, e);
    check(log_wr.size() == 1 && log_addr[0] == al_word(a), "R4 alias read targets word",
          log_addr.size() > 0 ? log_addr[0] : 32'hx, al_word(a));
  endtask

  initial begin
    rst_n = 1'b0; m_valid = 1'b0; m_write = 1'b0; m_addr = 32'h0; m_wdata = 32'h0;
    started = 1'b0;
    repeat (3) @(negedge clk);
    check(!s_valid && !m_rvalid, "R1 idle in reset", {s_valid, m_rvalid}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!s_valid && !m_rvalid, "R1 idle after reset", {s_valid, m_rvalid}, 32'h0);
    started = 1'b1;

    plain_wr(32'h2000_0000, 32'h0000_0000);
    plain_wr(32'h2000_0004, 32'hA5A5_0F0F);
    plain_wr(32'h400F_FFFC, 32'h0000_0000);
    plain_wr(32'h4000_0000, 32'hFFFF_FFFF);
    plain_wr(32'h21FF_FFFC, 32'h1234_5678);
    plain_wr(32'h2400_0000, 32'h8765_4321);
    plain_wr(32'h1000_0000, 32'hDEAD_BEEF);
    plain_rd(32'h2000_0004);
    plain_rd(32'h1000_0000);

    alias_wr(32'h2200_0000, 32'h1);            // R4 word 0x2000_0000 bit 0
    alias_wr(32'h2200_00B4, 32'h1);            // R4 word 0x2000_0004 bit 13
    alias_wr(32'h2200_0084, 32'hFFFF_FFFE);    // R6 bit 0 of data clears bit 1
    alias_wr(32'h43FF_FFFC, 32'h1);            // R3 top of window 1 -> 0x400F_FFFC bit 31
    alias_wr(32'h4200_0007, 32'h0);            // R4 low address bits ignored
    alias_rd(32'h2200_0000);
    alias_rd(32'h2200_00B4);
    alias_rd(32'h2200_0084);
    alias_rd(32'h43FF_FFFC);
    alias_rd(32'h4200_0004);
    alias_rd(32'h4200_0008);
    plain_rd(32'h21FF_FFFC);                   // R3 just below window 0
    plain_rd(32'h2400_0000);                   // R3 just above window 0
    plain_rd(32'h400F_FFFC);

    for (int i = 0; i < 60; i++) begin
      logic [31:0] a;
      int sel;
      sel = int'(lfsr[1:0]);
      a = (lfsr[8] ? 32'h4200_0000 : 32'h2200_0000) + {22'h0, lfsr[15:8], 2'b00};
      case (sel)
        0:       alias_wr(a, {31'h0, lfsr[3]});
        1:       alias_rd(a);
        2:       plain_wr(32'h2000_0000 + {24'h0, lfsr[11:6], 2'b00}, {lfsr, lfsr});
        default: plain_rd(al_word(a));
      endcase
    end

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule